// File: doc/BRIEF.md
# Power-Management Event, Timer and SCI Block

This block holds the PM1 event status, event enable and control registers of an ACPI-style power-management function, together with a free-running power-management timer. Software reaches them through a 64-byte I/O window whose base address and enable come from two configuration inputs, so the window can be moved or switched off at run time. The register bus carries 16-bit words with two byte-lane strobes.

Three external event lines feed the status register: a real-time-clock alarm, a power button and a global-lock release. A fourth status source is the carry out of the top bit of the timer. Each source latches a sticky status bit that software clears by writing a one. The block drives a level system-control interrupt (SCI) while any of these four sources has both its status and its enable bit set. The timer carry is armed only while its enable bit is set and its status bit is clear.

Top module: `pm1_evt_block`

## Requirements
- R1: After reset the status, enable, control and timer registers all read zero, and `sci` is low.
- R2: The window answers only while bit 0 of `cfg_win_ctl` is 1. An access hits when `io_addr[15:6]` equals `cfg_base_dw[15:6]`; the base is the dword ANDed with 0xFFC0. An access that misses leaves `io_rvalid` low and `io_rdata` zero, and a write that misses changes no register.
- R3: A read with `io_rd` high in a cycle gives `io_rvalid` and `io_rdata` at the next clock edge. The window offsets are 0x00 status, 0x02 enable, 0x04 control, 0x08 timer bits 15:0 and 0x0A timer bits 31:16 (zero-extended). Any other offset reads zero. On a write, `io_be[0]` enables data bits 7:0 and `io_be[1]` enables bits 15:8.
- R4: A rising edge on `evt_rtc`, `evt_pwrbtn` or `evt_glock` sets status bit 10, 8 or 5 respectively. An input that stays high does not set the bit again after it is cleared.
- R5: Status bits clear when a one is written to them at offset 0x00. A zero leaves them unchanged. A set in the same cycle as a clear wins.
- R6: `sci` is high exactly when (status AND enable) is non-zero in bit 0, 5, 8 or 10. The other enable bits have no effect on `sci`.
- R7: The timer is `TMR_W` bits wide and advances by one in each cycle that `tmr_tick` is high. A wrap from all ones to zero sets status bit 0 only if enable bit 0 is 1 and status bit 0 is 0. A wrap while the enable bit is clear is lost.
- R8: The control register at 0x04 is 16 bits of read/write storage. Bit 13 is a self-clearing sleep trigger that always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_dw | input | 32 | Configuration dword that supplies the window base |
| cfg_win_ctl | input | 8 | Configuration byte; bit 0 enables the window |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_be | input | 2 | Byte-lane enables for writes |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Registered read data |
| io_rvalid | output | 1 | Read data valid, one cycle after a read that hits |
| evt_rtc | input | 1 | Real-time-clock alarm event |
| evt_pwrbtn | input | 1 | Power button event |
| evt_glock | input | 1 | Global-lock release event |
| tmr_tick | input | 1 | Timer increment enable |
| sci | output | 1 | Registered level system-control interrupt |

## Verification
The bench builds the block with `TMR_W` = 8 and keeps the default 16-bit address space and 64-byte window. With an 8-bit timer a wrap takes only 256 ticks. That makes it practical to test an armed carry, a second carry while the status bit is still set, and a carry lost while the enable bit is clear, all within a short run. It also moves the base to a second aligned address and puts a low-order offset into the configuration dword, to show that the 0xFFC0 mask and the relocation both work.

// File: rtl/pm1_pkg.sv
package pm1_pkg;
  localparam int unsigned REG_W      = 16;
  // byte offsets inside the window
  localparam int unsigned OFF_STS    = 'h00;
  localparam int unsigned OFF_EN     = 'h02;
  localparam int unsigned OFF_CTL    = 'h04;
  localparam int unsigned OFF_TMR_LO = 'h08;
  localparam int unsigned OFF_TMR_HI = 'h0A;
  // bit positions shared by status and enable
  localparam int unsigned BIT_TMR    = 0;
  localparam int unsigned BIT_GLOCK  = 5;
  localparam int unsigned BIT_PWRBTN = 8;
  localparam int unsigned BIT_RTC    = 10;
  localparam int unsigned CTL_SC_BIT = 13;
  localparam logic [REG_W-1:0] SCI_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_GLOCK) | (1 << BIT_PWRBTN) | (1 << BIT_RTC));
  localparam int unsigned N_EXT = 3;

  // external event index -> status bit position
  function automatic int unsigned ext_pos(input int unsigned k);
    case (k)
      0:       ext_pos = BIT_RTC;
      1:       ext_pos = BIT_PWRBTN;
      default: ext_pos = BIT_GLOCK;
    endcase
  endfunction
endpackage

// File: rtl/pm1_win_decode.sv
module pm1_win_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 64,
  localparam int unsigned OFF_W    = $clog2(WIN_BYTES)
) (
  input  logic [31:0]       cfg_base_dw,
  input  logic [7:0]        cfg_win_ctl,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);
  logic unused_cfg;
  assign unused_cfg = ^{cfg_base_dw[31:ADDR_W], cfg_base_dw[OFF_W-1:0],
                        cfg_win_ctl[7:1], io_addr[0]};

  // base is the config dword masked down to a window-aligned address
  assign hit = cfg_win_ctl[0] &&
               (io_addr[ADDR_W-1:OFF_W] == cfg_base_dw[ADDR_W-1:OFF_W]);
  // 16-bit access: the byte-select bit is always ignored
  assign off = {io_addr[OFF_W-1:1], 1'b0};
endmodule

// File: rtl/pm1_timer.sv
module pm1_timer #(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [TMR_W-1:0] count,
  output logic             carry
);
  assign carry = tick && (&count);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  // R7
  tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
  import pm1_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] ev_in,
  input  logic             tmr_carry,
  input  logic [REG_W-1:0] clr_req,
  input  logic [REG_W-1:0] en_wdata,
  input  logic [REG_W-1:0] en_wmask,
  output logic [REG_W-1:0] sts_q,
  output logic [REG_W-1:0] en_q,
  output logic             sci_o
);
  logic [N_EXT-1:0] ev_prev;
  logic [N_EXT-1:0] rise;
  logic [REG_W-1:0] set_v;
  logic [REG_W-1:0] sts_d;
  logic [REG_W-1:0] en_d;
  logic             tmr_set;

  assign rise    = ev_in & ~ev_prev;
  assign tmr_set = tmr_carry && en_q[BIT_TMR] && !sts_q[BIT_TMR];

  always_comb begin
    set_v = '0;
    for (int unsigned k = 0; k < N_EXT; k++)
      set_v[ext_pos(k)] = rise[k];
    set_v[BIT_TMR] = tmr_set;
  end

  // set wins over a simultaneous write-one-to-clear
  assign sts_d = ((sts_q & ~clr_req) | set_v) & SCI_MASK;
  assign en_d  = (en_q & ~en_wmask) | (en_wdata & en_wmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_prev <= '0;
      sts_q   <= '0;
      en_q    <= '0;
      sci_o   <= 1'b0;
    end else begin
      ev_prev <= ev_in;
      sts_q   <= sts_d;
      en_q    <= en_d;
      sci_o   <= |(sts_d & en_d & SCI_MASK);
    end
  end

  generate
    for (genvar k = 0; k < N_EXT; k++) begin : g_ev_chk
      // R4
      evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        rise[k] |=> sts_q[ext_pos(k)]);
    end
    for (genvar b = 0; b < REG_W; b++) begin : g_hold_chk
      // R5
      sts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sts_q[b] && !clr_req[b] |=> sts_q[b]);
    end
  endgenerate

  // R6
  sci_chk: assert property (@(posedge clk) disable iff (rst)
    sci_o == (|(sts_q & en_q & SCI_MASK)));

  // R7
  tmr_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_q[BIT_TMR]) |-> $past(en_q[BIT_TMR]));
endmodule

// File: rtl/pm1_evt_block.sv
module pm1_evt_block
  import pm1_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 64,
  parameter int unsigned TMR_W     = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       cfg_base_dw,
  input  logic [7:0]        cfg_win_ctl,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [1:0]        io_be,
  input  logic [15:0]       io_wdata,
  output logic [15:0]       io_rdata,
  output logic              io_rvalid,
  input  logic              evt_rtc,
  input  logic              evt_pwrbtn,
  input  logic              evt_glock,
  input  logic              tmr_tick,
  output logic              sci
);
  localparam int unsigned OFF_W = $clog2(WIN_BYTES);
  localparam logic [OFF_W-1:0] O_STS = OFF_W'(OFF_STS);
  localparam logic [OFF_W-1:0] O_EN  = OFF_W'(OFF_EN);
  localparam logic [OFF_W-1:0] O_CTL = OFF_W'(OFF_CTL);
  localparam logic [OFF_W-1:0] O_TLO = OFF_W'(OFF_TMR_LO);
  localparam logic [OFF_W-1:0] O_THI = OFF_W'(OFF_TMR_HI);
  localparam logic [REG_W-1:0] CTL_WMASK = ~(REG_W'(1) << CTL_SC_BIT);

  logic             hit;
  logic [OFF_W-1:0] off;
  logic [REG_W-1:0] lane_m;
  logic             wr_go;
  logic [REG_W-1:0] clr_req;
  logic [REG_W-1:0] en_wmask;
  logic [REG_W-1:0] sts_q;
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] ctl_q;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_carry;
  logic [31:0]      tmr_ext;
  logic [REG_W-1:0] rd_mux;

  pm1_win_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_dec (
    .cfg_base_dw (cfg_base_dw),
    .cfg_win_ctl (cfg_win_ctl),
    .io_addr     (io_addr),
    .hit         (hit),
    .off         (off)
  );

  pm1_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .tick  (tmr_tick),
    .count (tmr_cnt),
    .carry (tmr_carry)
  );

  assign lane_m   = {{8{io_be[1]}}, {8{io_be[0]}}};
  assign wr_go    = io_wr && hit;
  assign clr_req  = (wr_go && off == O_STS) ? (io_wdata & lane_m) : '0;
  assign en_wmask = (wr_go && off == O_EN) ? lane_m : '0;

  pm1_evt_regs u_evt (
    .clk       (clk),
    .rst       (rst),
    .ev_in     ({evt_glock, evt_pwrbtn, evt_rtc}),
    .tmr_carry (tmr_carry),
    .clr_req   (clr_req),
    .en_wdata  (io_wdata),
    .en_wmask  (en_wmask),
    .sts_q     (sts_q),
    .en_q      (en_q),
    .sci_o     (sci)
  );

  // control: plain storage, self-clearing trigger bit never retained
  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= '0;
    else if (wr_go && off == O_CTL)
      ctl_q <= ((ctl_q & ~lane_m) | (io_wdata & lane_m)) & CTL_WMASK;
  end

  assign tmr_ext = 32'(tmr_cnt);

  always_comb begin
    case (off)
      O_STS:   rd_mux = sts_q;
      O_EN:    rd_mux = en_q;
      O_CTL:   rd_mux = ctl_q;
      O_TLO:   rd_mux = tmr_ext[15:0];
      O_THI:   rd_mux = tmr_ext[31:16];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= io_rd && hit;
      io_rdata  <= (io_rd && hit) ? rd_mux : '0;
    end
  end

  // R2
  win_off_chk: assert property (@(posedge clk) disable iff (rst)
    io_rd && !cfg_win_ctl[0] |=> !io_rvalid && io_rdata == '0);

  // R8
  ctl_sc_chk: assert property (@(posedge clk) disable iff (rst)
    io_rd && hit && off == O_CTL |=> !io_rdata[CTL_SC_BIT]);
endmodule

// File: tb/sim_pm1_evt_block.sv
`timescale 1ns/1ps
module sim_pm1_evt_block;
  localparam int TW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_base_dw = 32'h0000_E012;
  logic [7:0]  cfg_win_ctl = 8'h00;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [1:0]  io_be = 2'b00;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        io_rvalid;
  logic        evt_rtc = 1'b0, evt_pwrbtn = 1'b0, evt_glock = 1'b0;
  logic        tmr_tick = 1'b0;
  logic        sci;

  int checks = 0;
  int fails  = 0;
  int ticks  = 0;
  logic [15:0] base = 16'hE000;

  always #2 clk = ~clk;

  pm1_evt_block #(.TMR_W(TW)) u0 (
    .clk(clk), .rst(rst), .cfg_base_dw(cfg_base_dw), .cfg_win_ctl(cfg_win_ctl),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_be(io_be),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .evt_rtc(evt_rtc), .evt_pwrbtn(evt_pwrbtn), .evt_glock(evt_glock),
    .tmr_tick(tmr_tick), .sci(sci)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_be = be; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_be = 2'b00;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [15:0] d, output logic v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata; v = io_rvalid;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] off, input logic [15:0] exp);
    logic [15:0] d; logic v;
    io_read(base + off, d, v);
    chk({req, " rvalid"}, {15'd0, v}, 16'd1);
    chk(req, d, exp);
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tmr_tick = 1'b1;
    repeat (n) @(negedge clk);
    tmr_tick = 1'b0;
    ticks += n;
  endtask

  task automatic t_reset;
    logic [15:0] d; logic v;
    chk("R1 sci after reset", {15'd0, sci}, 16'd0);
    io_read(16'hE000, d, v);
    chk("R2 window disabled rvalid", {15'd0, v}, 16'd0);
    chk("R2 window disabled rdata", d, 16'd0);
    cfg_win_ctl = 8'hFE;
    io_read(16'hE000, d, v);
    chk("R2 bit0 clear keeps window shut", {15'd0, v}, 16'd0);
    cfg_win_ctl = 8'h01;
    rd_chk("R1 status zero", 16'h00, 16'h0000);
    rd_chk("R1 enable zero", 16'h02, 16'h0000);
    rd_chk("R1 control zero", 16'h04, 16'h0000);
    rd_chk("R1 timer zero", 16'h08, 16'h0000);
  endtask

  task automatic t_window;
    logic [15:0] d; logic v;
    io_write(base + 16'h02, 16'hA5C3, 2'b11);
    rd_chk("R3 enable word write", 16'h02, 16'hA5C3);
    io_write(base + 16'h02, 16'h1234, 2'b01);
    rd_chk("R3 low lane only", 16'h02, 16'hA534);
    io_write(base + 16'h02, 16'h7700, 2'b10);
    rd_chk("R3 high lane only", 16'h02, 16'h7734);
    rd_chk("R3 unmapped offset", 16'h0C, 16'h0000);
    io_write(base + 16'h02, 16'h0000, 2'b11);
    // relocate the window
    cfg_base_dw = 32'hABCD_1A7F;
    io_write(16'hE002, 16'hFFFF, 2'b11);
    io_read(16'hE002, d, v);
    chk("R2 old base no response", {15'd0, v}, 16'd0);
    base = 16'h1A40;
    rd_chk("R2 miss write ignored", 16'h02, 16'h0000);
    io_read(16'h1A80 + 16'h02, d, v);
    chk("R2 next window no hit", {15'd0, v}, 16'd0);
  endtask

  task automatic t_events;
    // enable only a non-SCI bit plus nothing else
    io_write(base + 16'h02, 16'hFADE & ~16'h0521, 2'b11);
    @(negedge clk); evt_rtc = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 rtc status without enable no sci", {15'd0, sci}, 16'd0);
    rd_chk("R4 rtc sets bit10", 16'h00, 16'h0400);
    io_write(base + 16'h02, 16'h0400, 2'b11);
    @(negedge clk);
    chk("R6 enable raises sci", {15'd0, sci}, 16'd1);
    io_write(base + 16'h00, 16'h0000, 2'b11);
    rd_chk("R5 zero write keeps status", 16'h00, 16'h0400);
    io_write(base + 16'h00, 16'h0400, 2'b11);
    @(negedge clk);
    chk("R5 clear drops sci", {15'd0, sci}, 16'd0);
    rd_chk("R4 held level no reset", 16'h00, 16'h0000);
    evt_rtc = 1'b0;
    @(negedge clk);
    // set versus clear in the same cycle
    evt_rtc = 1'b1;
    io_write(base + 16'h00, 16'h0000, 2'b11);
    evt_rtc = 1'b0;
    @(negedge clk);
    evt_rtc = 1'b1; io_addr = base; io_wdata = 16'h0400; io_be = 2'b11; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; evt_rtc = 1'b0;
    rd_chk("R5 set wins over clear", 16'h00, 16'h0400);
    io_write(base + 16'h00, 16'hFFFF, 2'b11);
    // power button and global lock
    io_write(base + 16'h02, 16'h0120, 2'b11);
    @(negedge clk); evt_pwrbtn = 1'b1; evt_glock = 1'b1;
    @(negedge clk); evt_pwrbtn = 1'b0; evt_glock = 1'b0;
    @(negedge clk);
    rd_chk("R4 pwrbtn and glock bits", 16'h00, 16'h0120);
    chk("R6 sci from pwrbtn/glock", {15'd0, sci}, 16'd1);
    io_write(base + 16'h00, 16'h0100, 2'b11);
    @(negedge clk);
    chk("R6 sci kept by glock", {15'd0, sci}, 16'd1);
    io_write(base + 16'h00, 16'h0020, 2'b01);
    @(negedge clk);
    chk("R6 sci low after all cleared", {15'd0, sci}, 16'd0);
  endtask

  task automatic t_timer;
    int need;
    rd_chk("R7 timer counts ticks", 16'h08, 16'(ticks % (1 << TW)));
    run_ticks(37);
    rd_chk("R7 timer after 37 ticks", 16'h08, 16'(ticks % (1 << TW)));
    rd_chk("R7 timer upper half", 16'h0A, 16'h0000);
    io_write(base + 16'h02, 16'h0001, 2'b11);
    need = (1 << TW) - (ticks % (1 << TW));
    run_ticks(need - 1);
    rd_chk("R7 no carry before wrap", 16'h00, 16'h0000);
    run_ticks(1);
    rd_chk("R7 carry sets bit0", 16'h00, 16'h0001);
    chk("R7 carry raises sci", {15'd0, sci}, 16'd1);
    run_ticks(1 << TW);
    rd_chk("R7 second carry keeps status", 16'h00, 16'h0001);
    io_write(base + 16'h00, 16'h0001, 2'b11);
    io_write(base + 16'h02, 16'h0000, 2'b11);
    run_ticks(1 << TW);
    rd_chk("R7 disabled carry lost", 16'h00, 16'h0000);
    chk("R7 sci low disabled carry", {15'd0, sci}, 16'd0);
    io_write(base + 16'h02, 16'h0001, 2'b11);
    @(negedge clk);
    chk("R7 late enable no stale carry", {15'd0, sci}, 16'd0);
  endtask

  task automatic t_ctl;
    io_write(base + 16'h04, 16'hFFFF, 2'b11);
    rd_chk("R8 bit13 self-clears", 16'h04, 16'hDFFF);
    io_write(base + 16'h04, 16'h2001, 2'b11);
    rd_chk("R8 control storage", 16'h04, 16'h0001);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_window();
    t_events();
    t_timer();
    t_ctl();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule